// File: doc/BRIEF.md
# Timed Non-Volatile Byte Store Write Controller

This block fronts a 32-byte non-volatile data store. The store is an array of registers with no reset, so its contents survive a soft reset of the controller. A CPU-side 8-bit control register selects the programming clock and gates reads and writes. Any subset of its bits can be updated in one access through a bit mask, so single-bit updates and full-byte writes use the same port.

A write request does not reach the array at once. The controller accepts it only when writes are enabled and no other write is running. It then captures the address, the data byte and the clock-select code into latches. A program cycle follows, timed by a prescaler tap of the system clock divided by 32, 64 or 128. The cycle lasts a fixed number of prescaler ticks, set by a parameter. While it runs the busy flag is high. At its last tick the array takes the latched byte, busy drops and a one-cycle interrupt request fires on the same edge. Reads are combinational from the array and return zero while reads are disabled.

Top module: `nvram_prog_ctrl`

## Requirements
- R1: After reset the control register reads 08H, busy is 0 and irq is 0.
- R2: A control write sets each bit whose ctlMask bit is 1 to the matching ctlWrData bit and leaves the other bits unchanged. The layout is: bits 2:0 clock-select code, bit 3 read enable, bit 4 write enable, bits 6:5 always read 0, bit 7 reads busy and cannot be written.
- R3: A write request with write enable 1 while idle is accepted on that clock edge, and busy (and control bit 7) reads 1 from the next cycle.
- R4: Busy stays 1 for exactly WRITE_TICKS x 2^(5+s) cycles after the accepting edge. Here s is the clock-select code when it is 0, 1 or 2; codes 3 to 7 act as code 2.
- R5: When busy clears, irq is 1 for exactly one cycle, and the array holds the new byte from that same cycle on.
- R6: A write request while write enable is 0 is ignored: busy stays 0 and the array is unchanged.
- R7: A write request while busy is ignored. It neither changes the array nor alters the running cycle's length.
- R8: With read enable 1, memRdData shows the byte stored at memAddr in the same cycle. With read enable 0 it reads 00H.
- R9: During a program cycle, the address being programmed reads its old value until the cycle completes.
- R10: Changing the clock-select code during a program cycle does not change that cycle's length. The new code times the next write.
- R11: Array contents survive a controller reset.
- R12: Address and data are captured at acceptance. Later changes on memAddr or memWrData do not affect what is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset of the controller (not the array) |
| ctlWrEn | input | 1 | Control register write strobe |
| ctlMask | input | 8 | Per-bit write mask for the control register |
| ctlWrData | input | 8 | Control register write data |
| ctlRdData | output | 8 | Control register read value |
| memWrReq | input | 1 | Array write request |
| memAddr | input | 5 | Array address for reads and write requests |
| memWrData | input | 8 | Byte to program |
| memRdData | output | 8 | Byte read from memAddr, or 00H with reads disabled |
| busy | output | 1 | Program cycle in progress |
| irq | output | 1 | One-cycle completion interrupt request |

## Verification
Control writes and array reads show at the ports in the cycle after the strobe edge and in the same cycle, so the bench drives on the falling edge and samples on the next falling edge. Busy rises one cycle after the accepting edge. It then falls exactly WRITE_TICKS x 2^(5+s) edges later, and irq and the new array byte appear in that same cycle. The bench counts rising edges from the acceptance to the first low busy sample and compares the count with its own figure for each select code. It checks irq in that sample and again one cycle later.

// File: rtl/nvp_pkg.sv
package nvp_pkg;
  localparam int CTL_W       = 8;
  localparam int SEL_W       = 3;
  localparam int SEL_LSB     = 0;
  localparam int RDEN_BIT    = 3;
  localparam int WREN_BIT    = 4;
  localparam int BUSY_BIT    = 7;
  localparam logic [CTL_W-1:0] CTL_RESET = 8'h08;

  typedef enum logic {ST_IDLE, ST_PROG} progState_t;

  typedef struct packed {
    logic capture;
    logic commit;
    logic readEn;
  } nvpStrobe_t;
endpackage

// File: rtl/nvp_prescaler.sv
module nvp_prescaler #(
  parameter int BASE_EXP = 5,
  parameter int NUM_TAPS = 3,
  parameter int SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int CNT_W = BASE_EXP + NUM_TAPS - 1;
  localparam int IDX_W = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1;

  logic [CNT_W-1:0]    cnt;
  logic [NUM_TAPS-1:0] tapHit;
  logic [IDX_W-1:0]    selIdx;

  // each tap fires when its low-order counter bits are all ones
  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    assign tapHit[k] = &cnt[BASE_EXP+k-1:0];
  end

  always_comb begin
    if (int'(sel) >= NUM_TAPS) selIdx = IDX_W'(NUM_TAPS - 1);
    else                       selIdx = IDX_W'(sel);
  end

  assign tick = run & tapHit[selIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cnt <= '0;
    else if (clear) cnt <= '0;
    else if (run)   cnt <= tick ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/nvp_ctrl.sv
module nvp_ctrl
  import nvp_pkg::*;
#(
  parameter int WRITE_TICKS = 4,
  parameter int BASE_EXP    = 5,
  parameter int NUM_TAPS    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWrEn,
  input  logic [CTL_W-1:0] ctlMask,
  input  logic [CTL_W-1:0] ctlWrData,
  output logic [CTL_W-1:0] ctlRdData,
  input  logic             memWrReq,
  output nvpStrobe_t       strobes,
  output logic             busy,
  output logic             irq
);
  localparam int TICK_W = (WRITE_TICKS > 1) ? $clog2(WRITE_TICKS) : 1;
  localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(WRITE_TICKS - 1);

  progState_t       state;
  logic [SEL_W-1:0] selReg;
  logic [SEL_W-1:0] activeSel;
  logic             rdEnReg;
  logic             wrEnReg;
  logic [TICK_W-1:0] tickCnt;
  logic             preTick;
  logic             accept;
  logic             finish;
  logic [CTL_W-1:0] ctlCur;
  logic [CTL_W-1:0] ctlNext;

  assign busy = (state == ST_PROG);

  always_comb begin
    ctlCur = '0;
    ctlCur[SEL_LSB +: SEL_W] = selReg;
    ctlCur[RDEN_BIT] = rdEnReg;
    ctlCur[WREN_BIT] = wrEnReg;
    ctlCur[BUSY_BIT] = busy;
  end
  assign ctlRdData = ctlCur;
  assign ctlNext   = (ctlCur & ~ctlMask) | (ctlWrData & ctlMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg  <= CTL_RESET[SEL_LSB +: SEL_W];
      rdEnReg <= CTL_RESET[RDEN_BIT];
      wrEnReg <= CTL_RESET[WREN_BIT];
    end else if (ctlWrEn) begin
      selReg  <= ctlNext[SEL_LSB +: SEL_W];
      rdEnReg <= ctlNext[RDEN_BIT];
      wrEnReg <= ctlNext[WREN_BIT];
    end
  end

  assign accept = memWrReq & wrEnReg & (state == ST_IDLE);
  assign finish = busy & preTick & (tickCnt == LAST_TICK);

  nvp_prescaler #(
    .BASE_EXP(BASE_EXP),
    .NUM_TAPS(NUM_TAPS),
    .SEL_W   (SEL_W)
  ) u_prescaler (
    .clk  (clk),
    .rstN (rstN),
    .clear(accept),
    .run  (busy),
    .sel  (activeSel),
    .tick (preTick)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      activeSel <= '0;
      tickCnt   <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= finish;
      unique case (state)
        ST_IDLE: if (accept) begin
          state     <= ST_PROG;
          activeSel <= selReg;
          tickCnt   <= '0;
        end
        ST_PROG: begin
          if (finish)       state   <= ST_IDLE;
          else if (preTick) tickCnt <= tickCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign strobes.capture = accept;
  assign strobes.commit  = finish;
  assign strobes.readEn  = rdEnReg;
endmodule

// File: rtl/nvp_datapath.sv
module nvp_datapath
  import nvp_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  nvpStrobe_t        strobes,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memWrData,
  output logic [DATA_W-1:0] memRdData
);
  logic [ADDR_W-1:0] addrLatch;
  logic [DATA_W-1:0] dataLatch;
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLatch <= '0;
      dataLatch <= '0;
    end else if (strobes.capture) begin
      addrLatch <= memAddr;
      dataLatch <= memWrData;
    end
  end

  // array has no reset so it keeps its contents through a controller reset
  always_ff @(posedge clk) begin
    if (strobes.commit) cells[addrLatch] <= dataLatch;
  end

  assign memRdData = strobes.readEn ? cells[memAddr] : '0;
endmodule

// File: rtl/nvram_prog_ctrl.sv
module nvram_prog_ctrl
  import nvp_pkg::*;
#(
  parameter int DEPTH       = 32,
  parameter int DATA_W      = 8,
  parameter int WRITE_TICKS = 4,
  parameter int BASE_EXP    = 5,
  parameter int NUM_TAPS    = 3,
  parameter int ADDR_W      = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWrEn,
  input  logic [7:0]        ctlMask,
  input  logic [7:0]        ctlWrData,
  output logic [7:0]        ctlRdData,
  input  logic              memWrReq,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memWrData,
  output logic [DATA_W-1:0] memRdData,
  output logic              busy,
  output logic              irq
);
  nvpStrobe_t strobes;

  nvp_ctrl #(
    .WRITE_TICKS(WRITE_TICKS),
    .BASE_EXP   (BASE_EXP),
    .NUM_TAPS   (NUM_TAPS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ctlWrEn  (ctlWrEn),
    .ctlMask  (ctlMask),
    .ctlWrData(ctlWrData),
    .ctlRdData(ctlRdData),
    .memWrReq (memWrReq),
    .strobes  (strobes),
    .busy     (busy),
    .irq      (irq)
  );

  nvp_datapath #(
    .DEPTH (DEPTH),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .memAddr  (memAddr),
    .memWrData(memWrData),
    .memRdData(memRdData)
  );
endmodule

// File: rtl/nvp_checker.sv
module nvp_checker #(
  parameter int DATA_W      = 8,
  parameter int WRITE_TICKS = 4,
  parameter int BASE_EXP    = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              memWrReq,
  input logic [7:0]        ctlRdData,
  input logic [DATA_W-1:0] memRdData,
  input logic              busy,
  input logic              irq
);
  localparam int MIN_LEN = WRITE_TICKS * (1 << BASE_EXP);
  int unsigned runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     runCnt <= 0;
    else if (busy) runCnt <= runCnt + 1;
    else           runCnt <= 0;
  end

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctlRdData[6:5] == 2'b00);
  p_accept_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memWrReq && ctlRdData[4] && !busy) |=> busy);
  p_min_length_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runCnt >= MIN_LEN));
  p_irq_on_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> irq);
  p_irq_needs_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ($past(busy) && !busy));
  p_irq_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);
  p_ignored_disabled_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memWrReq && !ctlRdData[4] && !busy) |=> !busy);
  p_read_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ctlRdData[3] |-> (memRdData == '0));
endmodule

bind nvram_prog_ctrl nvp_checker #(
  .DATA_W     (DATA_W),
  .WRITE_TICKS(WRITE_TICKS),
  .BASE_EXP   (BASE_EXP)
) u_nvp_checker (
  .clk      (clk),
  .rstN     (rstN),
  .memWrReq (memWrReq),
  .ctlRdData(ctlRdData),
  .memRdData(memRdData),
  .busy     (busy),
  .irq      (irq)
);

// File: tb/nvram_prog_ctrl_bench.sv
`timescale 1ns/1ps
module nvram_prog_ctrl_bench;
  localparam int TICKS = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctlWrEn = 1'b0;
  logic [7:0] ctlMask = '0;
  logic [7:0] ctlWrData = '0;
  logic [7:0] ctlRdData;
  logic       memWrReq = 1'b0;
  logic [4:0] memAddr = '0;
  logic [7:0] memWrData = '0;
  logic [7:0] memRdData;
  logic       busy;
  logic       irq;

  int total = 0;
  int bad = 0;
  int unsigned cyc = 0;
  int unsigned startCyc = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  nvram_prog_ctrl #(.WRITE_TICKS(TICKS)) u_nvram_prog_ctrl (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlMask(ctlMask),
    .ctlWrData(ctlWrData), .ctlRdData(ctlRdData), .memWrReq(memWrReq),
    .memAddr(memAddr), .memWrData(memWrData), .memRdData(memRdData),
    .busy(busy), .irq(irq)
  );

  function automatic int expLen(int sel);
    return TICKS * (32 << ((sel > 2) ? 2 : sel));
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctlWrite(logic [7:0] mask, logic [7:0] data);
    ctlWrEn = 1'b1; ctlMask = mask; ctlWrData = data;
    @(negedge clk);
    ctlWrEn = 1'b0; ctlMask = '0;
  endtask

  task automatic readAt(logic [4:0] a, output logic [7:0] v);
    memAddr = a;
    #1 v = memRdData;
  endtask

  task automatic startWrite(logic [4:0] a, logic [7:0] d);
    memWrReq = 1'b1; memAddr = a; memWrData = d;
    @(negedge clk);
    memWrReq = 1'b0;
    startCyc = cyc;
  endtask

  task automatic waitDone(string req, int expCycles);
    int guard = 0;
    while (busy && guard < 4000) begin
      @(negedge clk);
      guard++;
    end
    check(int'(cyc - startCyc) == expCycles, req, int'(cyc - startCyc), expCycles);
    check(irq == 1'b1, "R5 irq at clear", int'(irq), 1);
    @(negedge clk);
    check(irq == 1'b0, "R5 irq single", int'(irq), 0);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset_r1();
    check(ctlRdData == 8'h08, "R1 ctl reset", ctlRdData, 8'h08);
    check(busy == 1'b0, "R1 busy reset", int'(busy), 0);
    check(irq == 1'b0, "R1 irq reset", int'(irq), 0);
  endtask

  task automatic t_ctl_mask_r2();
    ctlWrite(8'h10, 8'hFF);
    check(ctlRdData == 8'h18, "R2 single bit set", ctlRdData, 8'h18);
    ctlWrite(8'h07, 8'h02);
    check(ctlRdData == 8'h1A, "R2 field write", ctlRdData, 8'h1A);
    ctlWrite(8'hE0, 8'hFF);
    check(ctlRdData == 8'h1A, "R2 read-only bits", ctlRdData, 8'h1A);
    ctlWrite(8'h07, 8'h00);
    check(ctlRdData == 8'h18, "R2 field clear", ctlRdData, 8'h18);
  endtask

  task automatic t_basic_write_r3(logic [4:0] a, logic [7:0] d);
    logic [7:0] v;
    startWrite(a, d);
    check(busy == 1'b1, "R3 busy after accept", int'(busy), 1);
    check(ctlRdData[7] == 1'b1, "R3 status bit", int'(ctlRdData[7]), 1);
    waitDone("R4 length sel0", expLen(0));
    readAt(a, v);
    check(v == d, "R8 readback", v, d);
  endtask

  task automatic t_sel_lengths_r4();
    int sels[3] = '{1, 2, 5};
    logic [7:0] v;
    foreach (sels[i]) begin
      ctlWrite(8'h07, 8'(sels[i]));
      startWrite(5'(10 + i), 8'(8'h40 + i));
      waitDone("R4 length", expLen(sels[i]));
      readAt(5'(10 + i), v);
      check(v == 8'(8'h40 + i), "R5 array updated", v, 8'(8'h40 + i));
    end
    ctlWrite(8'h07, 8'h00);
  endtask

  task automatic t_disabled_r6();
    logic [7:0] v;
    ctlWrite(8'h10, 8'h00);
    startWrite(5'd3, 8'hAA);
    check(busy == 1'b0, "R6 no busy", int'(busy), 0);
    repeat (3) @(negedge clk);
    readAt(5'd3, v);
    check(v == 8'h5A, "R6 array kept", v, 8'h5A);
    ctlWrite(8'h10, 8'h10);
  endtask

  task automatic t_busy_ignore_r7();
    logic [7:0] v;
    startWrite(5'd7, 8'h11);
    repeat (20) @(negedge clk);
    memWrReq = 1'b1; memAddr = 5'd8; memWrData = 8'h22;
    @(negedge clk);
    memWrReq = 1'b0;
    waitDone("R7 length unchanged", expLen(0));
    readAt(5'd8, v);
    check(v == 8'h33, "R7 second write dropped", v, 8'h33);
    readAt(5'd7, v);
    check(v == 8'h11, "R7 first write kept", v, 8'h11);
  endtask

  task automatic t_old_value_r9();
    logic [7:0] v;
    startWrite(5'd3, 8'hC3);
    repeat (50) @(negedge clk);
    readAt(5'd3, v);
    check(v == 8'h5A, "R9 old value while busy", v, 8'h5A);
    waitDone("R9 length", expLen(0));
    readAt(5'd3, v);
    check(v == 8'hC3, "R9 new value after", v, 8'hC3);
  endtask

  task automatic t_sel_change_r10();
    startWrite(5'd20, 8'h77);
    repeat (10) @(negedge clk);
    ctlWrite(8'h07, 8'h02);
    waitDone("R10 length kept", expLen(0));
    startWrite(5'd21, 8'h78);
    waitDone("R10 next uses new sel", expLen(2));
    ctlWrite(8'h07, 8'h00);
  endtask

  task automatic t_read_off_r8();
    logic [7:0] v;
    ctlWrite(8'h08, 8'h00);
    readAt(5'd3, v);
    check(v == 8'h00, "R8 read disabled", v, 8'h00);
    ctlWrite(8'h08, 8'h08);
    readAt(5'd3, v);
    check(v == 8'hC3, "R8 read enabled", v, 8'hC3);
  endtask

  task automatic t_latch_r12();
    logic [7:0] v;
    startWrite(5'd25, 8'h9C);
    memAddr = 5'd26; memWrData = 8'h01;
    waitDone("R12 length", expLen(0));
    readAt(5'd25, v);
    check(v == 8'h9C, "R12 latched write", v, 8'h9C);
  endtask

  task automatic t_retain_r11();
    logic [7:0] v;
    doReset();
    check(ctlRdData == 8'h08, "R11 ctl after reset", ctlRdData, 8'h08);
    readAt(5'd3, v);
    check(v == 8'hC3, "R11 array kept", v, 8'hC3);
    readAt(5'd25, v);
    check(v == 8'h9C, "R11 array kept b", v, 8'h9C);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finishRun();
  end

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset_r1();
    t_ctl_mask_r2();
    ctlWrite(8'h10, 8'h10);
    t_basic_write_r3(5'd3, 8'h5A);
    t_basic_write_r3(5'd8, 8'h33);
    t_sel_lengths_r4();
    t_disabled_r6();
    t_busy_ignore_r7();
    t_old_value_r9();
    t_sel_change_r10();
    t_read_off_r8();
    t_latch_r12();
    t_retain_r11();
    finishRun();
  end
endmodule